// File: doc/BRIEF.md
# 1-Wire Search Triplet Accelerator

This block sits between a byte-wide data register and a 1-Wire bit-slot engine. It speeds up the ROM search tree walk. In search mode, one write of the data byte carries four route choices, one for each of four consecutive ROM bit positions. For every position the block runs a read-read-write triplet on the bus: it reads the true bit, then the complement bit, then writes back the direction it chose. It records the chosen bit together with a flag that shows whether the responding devices disagreed at that position. After four positions the block packs these into one received byte and raises the receive-full flag. A whole 64-bit ROM therefore takes sixteen exchanges, starting with the least significant nibble.

When search mode is off, a written byte is sent as an ordinary 8-slot exchange, least significant bit first, and the bits returned by the bus are collected into the received byte. The mode is latched at the moment the byte is written.

The bus side is a request/done handshake towards a slot engine. `slot_bit` is the level to write; a read slot is a write-1 slot. The engine returns the sampled bus level in `slot_rbit` together with `slot_done`.

Top module: `owsa_search_accel`

## Requirements
- R1: After reset, `busy`, `slot_req` and `rx_full` are 0 and `rx_byte` is 0x00.
- R2: With `accel_en` low at the byte write, the block issues 8 slots; slot k drives `tx_byte[k]`, and the level returned in slot k lands in `rx_byte[k]`.
- R3: With `accel_en` high at the byte write, the block issues 12 slots: for each of four ROM positions two read slots with `slot_bit`=1, then one write slot.
- R4: In search mode, the route choice for position k is taken from `tx_byte[2k+1]`, and the even bits of `tx_byte` have no effect.
- R5: If the true and complement reads differ, the chosen bit equals the true read and the discrepancy flag is 0.
- R6: If both reads are 0, the discrepancy flag is 1 and the chosen bit equals the route choice.
- R7: If both reads are 1, the chosen bit and the discrepancy flag are both 1, and the write slot drives 1.
- R8: In search mode, `rx_byte[2k+1]` holds the chosen bit of position k and `rx_byte[2k]` holds its discrepancy flag; the write slot of position k drives that chosen bit.
- R9: `rx_full` rises the cycle after an exchange completes in either mode, and `rx_ack` without a completion in the same cycle clears it.
- R10: A change of `accel_en` during an exchange has no effect on that exchange.
- R11: A `tx_wr` pulse while `busy` is high is ignored.
- R12: `slot_req` stays high with a stable `slot_bit` until `slot_done`, and drops in the following cycle.
- R13: Sixteen search exchanges walk a 64-bit ROM, least significant nibble first. When no device responds, the final chosen bit and its discrepancy flag are both 1, which marks a bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accel_en | input | 1 | Search mode select, sampled at the byte write |
| tx_wr | input | 1 | Byte write strobe |
| tx_byte | input | 8 | Written byte (route choices in odd bits in search mode) |
| rx_ack | input | 1 | Received byte consumed; clears `rx_full` |
| slot_done | input | 1 | Slot engine finished the requested slot |
| slot_rbit | input | 1 | Bus level sampled in the finished slot |
| busy | output | 1 | Exchange in progress |
| rx_full | output | 1 | Received byte valid |
| rx_byte | output | 8 | Received byte |
| slot_req | output | 1 | Slot request, held until `slot_done` |
| slot_bit | output | 1 | Level to write in the requested slot (1 for a read slot) |

## Verification
The bench builds the block with its default of four ROM positions per exchange, which gives an 8-bit data byte and 12-slot search exchanges. With this setting, sixteen exchanges cover a full 64-bit ROM, so a modelled two-device bus can be walked end to end along both branches of a discrepancy, and an empty bus reaches the bit-63 bus-error pattern. A table-driven responder forces each read pair (differing, both 0, both 1) at chosen positions, so each decision rule can be checked against both the packed byte and the levels written back on the bus.

// File: rtl/owsa_pkg.sv
package owsa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_SLOT  = 2'd2
  } owsa_state_t;

  typedef enum logic [1:0] {
    PH_TRUE = 2'd0,
    PH_CMP  = 2'd1,
    PH_DIR  = 2'd2
  } owsa_phase_t;

endpackage

// File: rtl/owsa_decide.sv
module owsa_decide (
  input  logic rd_true,
  input  logic rd_cmp,
  input  logic route,
  output logic dir,
  output logic disc
);
  always_comb begin
    case ({rd_true, rd_cmp})
      2'b10:   begin dir = 1'b1;  disc = 1'b0; end
      2'b01:   begin dir = 1'b0;  disc = 1'b0; end
      2'b00:   begin dir = route; disc = 1'b1; end
      default: begin dir = 1'b1;  disc = 1'b1; end
    endcase
  end

  // r5 / r6 / r7: decision rule consistency
  always_comb begin
    if (rd_true != rd_cmp)
      a_r5_differ_rule: assert (dir == rd_true && !disc);
    if (!rd_true && !rd_cmp)
      a_r6_zero_rule: assert (disc && dir == route);
  end
endmodule

// File: rtl/owsa_lanes.sv
module owsa_lanes #(
  parameter int LANES = 4
) (
  input  logic [2*LANES-1:0] tx_q,
  input  logic [LANES-1:0]   dir_vec,
  input  logic [LANES-1:0]   disc_vec,
  output logic [LANES-1:0]   route_vec,
  output logic [2*LANES-1:0] packed_rx
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign route_vec[k]     = tx_q[2*k+1];
    assign packed_rx[2*k+1] = dir_vec[k];
    assign packed_rx[2*k]   = disc_vec[k];
  end
endmodule

// File: rtl/owsa_seq.sv
module owsa_seq
  import owsa_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  accel_en,
  input  logic                  tx_wr,
  input  logic [2*LANES-1:0]    tx_byte,
  input  logic [LANES-1:0]      route_vec,
  input  logic                  slot_done,
  input  logic                  slot_rbit,
  output logic                  slot_req,
  output logic                  slot_bit,
  output logic                  busy,
  output logic                  xfer_done,
  output logic                  accel_q,
  output logic [2*LANES-1:0]    tx_q,
  output logic [LANES-1:0]      dir_vec,
  output logic [LANES-1:0]      disc_vec,
  output logic [2*LANES-1:0]    norm_rx
);
  localparam int BYTE_W    = 2 * LANES;
  localparam int IDX_W     = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(LANES - 1);
  localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(BYTE_W - 1);

  owsa_state_t       st;
  owsa_phase_t       ph;
  logic [IDX_W-1:0]  idx;
  logic              t_q, c_q;
  logic              route_bit, tx_bit;
  logic              dec_dir, dec_disc;

  always_comb begin
    route_bit = 1'b0;
    for (int k = 0; k < LANES; k++)
      if (idx == IDX_W'(k)) route_bit = route_vec[k];
    tx_bit = 1'b0;
    for (int k = 0; k < BYTE_W; k++)
      if (idx == IDX_W'(k)) tx_bit = tx_q[k];
  end

  owsa_decide u_decide (
    .rd_true (t_q),
    .rd_cmp  (c_q),
    .route   (route_bit),
    .dir     (dec_dir),
    .disc    (dec_disc)
  );

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ph        <= PH_TRUE;
      idx       <= '0;
      t_q       <= 1'b0;
      c_q       <= 1'b0;
      accel_q   <= 1'b0;
      tx_q      <= '0;
      dir_vec   <= '0;
      disc_vec  <= '0;
      norm_rx   <= '0;
      slot_req  <= 1'b0;
      slot_bit  <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (tx_wr) begin
            tx_q    <= tx_byte;
            accel_q <= accel_en;
            idx     <= '0;
            ph      <= PH_TRUE;
            st      <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          slot_req <= 1'b1;
          st       <= ST_SLOT;
          if (accel_q) begin
            if (ph == PH_DIR) begin
              slot_bit <= dec_dir;
              for (int k = 0; k < LANES; k++)
                if (idx == IDX_W'(k)) begin
                  dir_vec[k]  <= dec_dir;
                  disc_vec[k] <= dec_disc;
                end
            end else begin
              slot_bit <= 1'b1;
            end
          end else begin
            slot_bit <= tx_bit;
          end
        end
        ST_SLOT: begin
          if (slot_done) begin
            slot_req <= 1'b0;
            if (accel_q) begin
              case (ph)
                PH_TRUE: begin t_q <= slot_rbit; ph <= PH_CMP; st <= ST_ISSUE; end
                PH_CMP:  begin c_q <= slot_rbit; ph <= PH_DIR; st <= ST_ISSUE; end
                default: begin
                  if (idx == LAST_LANE) begin
                    st        <= ST_IDLE;
                    xfer_done <= 1'b1;
                  end else begin
                    idx <= idx + 1'b1;
                    ph  <= PH_TRUE;
                    st  <= ST_ISSUE;
                  end
                end
              endcase
            end else begin
              for (int k = 0; k < BYTE_W; k++)
                if (idx == IDX_W'(k)) norm_rx[k] <= slot_rbit;
              if (idx == LAST_BIT) begin
                st        <= ST_IDLE;
                xfer_done <= 1'b1;
              end else begin
                idx <= idx + 1'b1;
                st  <= ST_ISSUE;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // r12: request handshake
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    (slot_req && !slot_done) |=> (slot_req && $stable(slot_bit)));
  a_r12_req_drop: assert property (@(posedge clk) disable iff (rst)
    (slot_req && slot_done) |=> !slot_req);
  // r3: both read slots of a triplet are write-1 slots
  a_r3_read_slot_one: assert property (@(posedge clk) disable iff (rst)
    (slot_req && accel_q && ph != PH_DIR) |-> slot_bit);
  // r5: differing reads steer the written direction to the true bit
  a_r5_write_true: assert property (@(posedge clk) disable iff (rst)
    (slot_req && accel_q && ph == PH_DIR && (t_q != c_q)) |-> (slot_bit == t_q));
  // r7: both-one reads still write a one
  a_r7_write_one: assert property (@(posedge clk) disable iff (rst)
    (slot_req && accel_q && ph == PH_DIR && t_q && c_q) |-> slot_bit);
  // r10 / r11: latched byte and mode stay put during an exchange
  a_r11_hold_byte: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(tx_q) && $stable(accel_q)));
endmodule

// File: rtl/owsa_search_accel.sv
module owsa_search_accel #(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accel_en,
  input  logic                 tx_wr,
  input  logic [2*LANES-1:0]   tx_byte,
  input  logic                 rx_ack,
  input  logic                 slot_done,
  input  logic                 slot_rbit,
  output logic                 busy,
  output logic                 rx_full,
  output logic [2*LANES-1:0]   rx_byte,
  output logic                 slot_req,
  output logic                 slot_bit
);
  localparam int BYTE_W = 2 * LANES;

  logic              xfer_done, accel_q;
  logic [BYTE_W-1:0] tx_q, norm_rx, packed_rx;
  logic [LANES-1:0]  route_vec, dir_vec, disc_vec;

  owsa_lanes #(.LANES(LANES)) u_lanes (
    .tx_q      (tx_q),
    .dir_vec   (dir_vec),
    .disc_vec  (disc_vec),
    .route_vec (route_vec),
    .packed_rx (packed_rx)
  );

  owsa_seq #(.LANES(LANES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .accel_en  (accel_en),
    .tx_wr     (tx_wr),
    .tx_byte   (tx_byte),
    .route_vec (route_vec),
    .slot_done (slot_done),
    .slot_rbit (slot_rbit),
    .slot_req  (slot_req),
    .slot_bit  (slot_bit),
    .busy      (busy),
    .xfer_done (xfer_done),
    .accel_q   (accel_q),
    .tx_q      (tx_q),
    .dir_vec   (dir_vec),
    .disc_vec  (disc_vec),
    .norm_rx   (norm_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full <= 1'b0;
      rx_byte <= '0;
    end else if (xfer_done) begin
      rx_full <= 1'b1;
      rx_byte <= accel_q ? packed_rx : norm_rx;
    end else if (rx_ack) begin
      rx_full <= 1'b0;
    end
  end

  // r9: receive flag set on completion, cleared by acknowledge
  a_r9_full_set: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> rx_full);
  a_r9_full_clear: assert property (@(posedge clk) disable iff (rst)
    (rx_ack && !xfer_done) |=> !rx_full);
endmodule

// File: tb/owsa_search_accel_test.sv
module owsa_search_accel_test;
  localparam int LANES = 4;
  localparam int BW    = 2 * LANES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic accel_en = 1'b0, tx_wr = 1'b0, rx_ack = 1'b0;
  logic [BW-1:0] tx_byte = '0;
  logic slot_done, slot_rbit;
  logic busy, rx_full, slot_req, slot_bit;
  logic [BW-1:0] rx_byte;

  always #5 clk = ~clk;

  owsa_search_accel #(.LANES(LANES)) uut (
    .clk(clk), .rst(rst), .accel_en(accel_en), .tx_wr(tx_wr),
    .tx_byte(tx_byte), .rx_ack(rx_ack), .slot_done(slot_done),
    .slot_rbit(slot_rbit), .busy(busy), .rx_full(rx_full),
    .rx_byte(rx_byte), .slot_req(slot_req), .slot_bit(slot_bit)
  );

  int n_chk = 0, n_fail = 0;

  // bus model: 0 = byte echo, 1 = forced read table, 2 = device set
  int          model = 0;
  logic [7:0]  dev_byte;
  logic [3:0]  t_tab, c_tab, wr_log;
  logic [63:0] bit_log;
  int          slot_cnt;
  logic [63:0] rom [2];
  logic [1:0]  present, active;
  int          pos;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic respond(input logic w, output logic r);
    int ph, b;
    ph = slot_cnt % 3;
    b  = slot_cnt / 3;
    r  = w;
    if (model == 0) begin
      r = w & dev_byte[slot_cnt % 8];
    end else if (model == 1) begin
      if (b < 4) begin
        if (ph == 0) r = t_tab[b];
        else if (ph == 1) r = c_tab[b];
        else wr_log[b] = w;
      end
    end else begin
      if (ph == 2) begin
        for (int i = 0; i < 2; i++)
          if (active[i] && rom[i][pos] != w) active[i] = 1'b0;
        pos++;
      end else begin
        r = 1'b1;
        for (int i = 0; i < 2; i++)
          if (active[i]) r = r & (ph == 0 ? rom[i][pos] : ~rom[i][pos]);
      end
    end
    if (slot_cnt < 64) bit_log[slot_cnt] = w;
    slot_cnt++;
  endtask

  // slot engine responder: fixed latency of three cycles per slot
  initial begin
    logic pend;
    logic r;
    int   cnt;
    pend = 1'b0; cnt = 0;
    slot_done = 1'b0; slot_rbit = 1'b0;
    forever begin
      @(posedge clk); #1;
      slot_done = 1'b0;
      if (slot_req && !pend) begin
        pend = 1'b1; cnt = 3;
      end else if (pend) begin
        cnt--;
        if (cnt == 0) begin
          respond(slot_bit, r);
          slot_rbit = r;
          slot_done = 1'b1;
          pend = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  task automatic start_byte(input logic [BW-1:0] tx, input logic acc);
    while (busy) @(negedge clk);
    @(negedge clk);
    accel_en = acc; tx_byte = tx; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic wait_rx(output logic [BW-1:0] rx);
    while (!rx_full) @(negedge clk);
    rx = rx_byte;
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
  endtask

  task automatic xchg(input logic [BW-1:0] tx, input logic acc, output logic [BW-1:0] rx);
    start_byte(tx, acc);
    wait_rx(rx);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 slot_req", slot_req, 0);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 rx_byte", rx_byte, 0);
  endtask

  task automatic t_normal();
    logic [BW-1:0] rx;
    model = 0; dev_byte = 8'h3C; slot_cnt = 0; bit_log = '0;
    start_byte(8'hFF, 1'b0);
    while (!rx_full) @(negedge clk);
    chk("R9 rx_full set", rx_full, 1);
    wait_rx(rx);
    @(negedge clk);
    chk("R9 rx_full cleared", rx_full, 0);
    chk("R2 rx bits", rx, 8'h3C);
    chk("R2 slot count", slot_cnt, 8);
    chk("R2 written levels", bit_log[7:0], 8'hFF);
    dev_byte = 8'hFF; slot_cnt = 0; bit_log = '0;
    xchg(8'hA5, 1'b0, rx);
    chk("R2 echo byte", rx, 8'hA5);
    chk("R2 lsb-first levels", bit_log[7:0], 8'hA5);
  endtask

  // position 0 differs (1,0), 1 differs (0,1), 2 both zero, 3 both one
  task automatic t_decide();
    logic [BW-1:0] rx;
    model = 1; t_tab = 4'b1001; c_tab = 4'b1010;
    wr_log = '0; slot_cnt = 0; bit_log = '0;
    xchg(8'h20, 1'b1, rx);
    chk("R8 packed byte route1", rx, 8'hF2);
    chk("R5 R6 R7 written dirs", wr_log, 4'b1101);
    chk("R3 slot count", slot_cnt, 12);
    chk("R3 R7 slot levels", bit_log[11:0], 12'hFDF);
    wr_log = '0; slot_cnt = 0;
    xchg(8'h55, 1'b1, rx);
    chk("R4 R6 even bits ignored, route0", rx, 8'hD2);
    chk("R6 written dirs route0", wr_log, 4'b1001);
  endtask

  task automatic t_latch();
    logic [BW-1:0] rx;
    model = 1; t_tab = 4'b1001; c_tab = 4'b1010;
    wr_log = '0; slot_cnt = 0;
    start_byte(8'h20, 1'b1);
    repeat (5) @(negedge clk);
    accel_en = 1'b0; tx_byte = 8'h00; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    wait_rx(rx);
    repeat (20) @(negedge clk);
    chk("R10 R11 byte unchanged", rx, 8'hF2);
    chk("R10 R11 slot count", slot_cnt, 12);
    chk("R11 no extra exchange", busy, 0);
  endtask

  task automatic search_pass(input logic [63:0] route, output logic [63:0] chosen,
                             output logic [63:0] disc);
    logic [BW-1:0] rx, tx;
    model = 2; active = present; pos = 0; slot_cnt = 0;
    chosen = '0; disc = '0;
    for (int i = 0; i < 16; i++) begin
      tx = '0;
      for (int k = 0; k < 4; k++) tx[2*k+1] = route[4*i+k];
      xchg(tx, 1'b1, rx);
      for (int k = 0; k < 4; k++) begin
        chosen[4*i+k] = rx[2*k+1];
        disc[4*i+k]   = rx[2*k];
      end
    end
  endtask

  task automatic t_search();
    logic [63:0] ch, ds;
    rom[0] = 64'h0F0E_0D0C_0B0A_0901;
    rom[1] = 64'h0F0E_0D0C_0B0A_0921;
    present = 2'b11;
    search_pass(64'h0, ch, ds);
    chk("R13 first branch rom", ch, rom[0]);
    chk("R13 first branch discrepancy", ds, 64'h20);
    chk("R13 slots for full walk", slot_cnt, 192);
    search_pass(64'h20, ch, ds);
    chk("R13 second branch rom", ch, rom[1]);
    chk("R13 second branch discrepancy", ds, 64'h20);
    present = 2'b00;
    search_pass(64'h0, ch, ds);
    chk("R13 empty bus bit63 pair", {ch[63], ds[63]}, 2'b11);
    chk("R7 empty bus all ones", ch & ds, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_decide();
    t_latch();
    t_search();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule